// File: doc/BRIEF.md
# Serial register access slave

This block lets a host processor read and write a bank of 16-bit configuration registers over a four-wire synchronous serial link. The link has an active-low select, a shift clock supplied by the host, a data input and a data output. Each access opens when select falls. The first 16 bits form a command word: a direction flag in bit 15, three ignored bits, and a 12-bit register address. One or more 16-bit data words follow. Input bits are taken on rising clock edges. Read data is launched on falling edges, so the host can capture each bit on the next rising edge.

The register contents are presented in parallel to the surrounding logic. One address is reserved for a read-only status word supplied from outside. Register 0 configures the output pin. When bit 0 is set, several chains, each with its own select, can share one data-out line: the pin is released whenever this device has no read data to drive. When bit 1 is set, the pin is released at all times. The block has no clock of its own and does all of its work on the host's shift clock.

Top module: `ser_reg_slave`

## Requirements
- R1: After rst_n is asserted, every register reads 0, and with register 0 at 0 the data-out pin is driven low while idle.
- R2: A command word with bit 15 = 0 writes the data word, received MSB first, to the register at command bits 11:0. Command bits 14:12 have no effect on the access.
- R3: A write takes effect only after all 16 data bits have arrived. If select rises before then, the partial word is discarded and the register keeps its old value.
- R4: A command word with bit 15 = 1 returns the addressed register MSB first. The value is captured at the last command bit. Each output bit changes only on a falling clock edge, so it is stable across the following rising edge.
- R5: During a read, each further 16-bit word clocked while select stays low returns the same register again.
- R6: While select is high, the clock and data input have no effect. Select falling always restarts command-word reception, even after an aborted access.
- R7: With register 0 bit 0 = 1 (shared-output mode), data-out is high impedance while select is high and during command words and write data. It is driven only while read data is being sent.
- R8: With register 0 bits 1:0 = 00, data-out is always driven, and it is low whenever no read data is being sent.
- R9: With register 0 bit 1 = 1, data-out is high impedance at all times, whatever bit 0 holds.
- R10: The status address returns status_i and ignores writes. Addresses at or above NUM_REGS read as 0, and writes to them change no register.
- R11: In a write, each further 16-bit data word commits again to the same address when its last bit arrives.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rst_n | input | 1 | Asynchronous active-low reset of the register bank and shift state |
| sclk | input | 1 | Serial shift clock from the host |
| cs_n | input | 1 | Active-low select; falling edge starts an access |
| sdin | input | 1 | Serial data in, sampled on rising sclk |
| sdout | output | 1 | Serial data out, launched on falling sclk, tri-statable |
| status_i | input | 16 | Read-only word returned at the status address |
| regs_o | output | NUM_REGS*16 | Parallel view of the register bank, register k at bits 16k+15:16k |

## Verification
The bench builds the block with NUM_REGS = 6 and the status address at 5. The status address therefore falls inside the bank's index range, which shows that writes to it are blocked even though a storage slot exists at that index. The depth of 6 is not a power of two, so addresses 6 and 0x020 test the range check: addresses that alias onto existing slots through the low index bits must still read 0 and must not write. A pull-up on the shared data-out line makes a released pin read as 1, so the bench can tell the output-release modes apart from a driven low.

// File: rtl/ser_reg_slave.sv
module ser_reg_slave #(
  parameter int NUM_REGS = 8,
  parameter logic [11:0] STATUS_ADDR = 12'h0FF
) (
  input  logic                   rst_n,
  input  logic                   sclk,
  input  logic                   cs_n,
  input  logic                   sdin,
  output logic                   sdout,
  input  logic [15:0]            status_i,
  output logic [NUM_REGS*16-1:0] regs_o
);
  localparam int IW = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

  logic [15:0] regs [NUM_REGS];
  logic        clr;
  logic [3:0]  cnt;
  logic        in_cmd;
  logic [14:0] sreg;
  logic        rw;
  logic [11:0] addr;
  logic [15:0] rd_word;
  logic        drv;
  logic        dq;

  assign clr = cs_n | ~rst_n;

  wire [15:0] word_in  = {sreg, sdin};
  wire        last     = (cnt == 4'hF);
  wire [11:0] sel_addr = in_cmd ? word_in[11:0] : addr;
  wire        in_range = 32'(sel_addr) < NUM_REGS;
  wire [IW-1:0] idx    = sel_addr[IW-1:0];
  wire        is_stat  = (sel_addr == STATUS_ADDR);

  logic [15:0] rd_val;
  always_comb begin
    if (is_stat)       rd_val = status_i;
    else if (in_range) rd_val = regs[idx];
    else               rd_val = 16'h0000;
  end

  wire wr_commit = !in_cmd && !rw && last && in_range && !is_stat;

  always_ff @(posedge sclk or posedge clr) begin
    if (clr) begin
      cnt     <= 4'h0;
      in_cmd  <= 1'b1;
      sreg    <= 15'h0;
      rw      <= 1'b0;
      addr    <= 12'h0;
      rd_word <= 16'h0;
    end else begin
      sreg <= word_in[14:0];
      cnt  <= cnt + 4'h1;
      if (last) begin
        if (in_cmd) begin
          in_cmd  <= 1'b0;
          rw      <= word_in[15];
          addr    <= word_in[11:0];
          rd_word <= word_in[15] ? rd_val : 16'h0;
        end else if (rw) begin
          rd_word <= rd_val;
        end
      end
    end
  end

  always_ff @(posedge sclk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_REGS; i++) regs[i] <= 16'h0;
    end else if (wr_commit) begin
      regs[idx] <= word_in;
    end
  end

  always_ff @(negedge sclk or posedge clr) begin
    if (clr) begin
      drv <= 1'b0;
      dq  <= 1'b0;
    end else begin
      drv <= !in_cmd && rw;
      dq  <= (!in_cmd && rw) ? rd_word[~cnt] : 1'b0;
    end
  end

  wire shared_out = regs[0][0];
  wire link_off   = regs[0][1];
  wire oe         = !link_off && (!shared_out || drv);

  assign sdout = oe ? dq : 1'bz;

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_flat
    assign regs_o[g*16 +: 16] = regs[g];
  end
endmodule

// File: rtl/ser_reg_slave_chk.sv
module ser_reg_slave_chk #(
  parameter int NUM_REGS = 8
) (
  input logic                   sclk,
  input logic                   rst_n,
  input logic                   cs_n,
  input logic                   clr,
  input logic                   in_cmd,
  input logic [3:0]             cnt,
  input logic [NUM_REGS*16-1:0] regs_o
);
  // R1
  always @(posedge sclk) begin
    if (!rst_n) begin
      reset_clear_chk: assert (regs_o == '0);
    end
  end

  // R6
  idle_hold_chk: assert property (@(posedge sclk) disable iff (!rst_n)
    cs_n |=> $stable(regs_o));

  // R2
  cmd_len_chk: assert property (@(posedge sclk) disable iff (clr)
    $fell(in_cmd) |-> ($past(cnt) == 4'hF));

  // R3
  commit_point_chk: assert property (@(posedge sclk) disable iff (clr)
    !$stable(regs_o) |-> ($past(cnt) == 4'hF && !$past(in_cmd)));

  // R6
  bit_count_chk: assert property (@(posedge sclk) disable iff (clr)
    1'b1 |=> (cnt == $past(cnt) + 4'h1));
endmodule

bind ser_reg_slave ser_reg_slave_chk #(.NUM_REGS(NUM_REGS)) u_chk (
  .sclk(sclk), .rst_n(rst_n), .cs_n(cs_n), .clr(clr),
  .in_cmd(in_cmd), .cnt(cnt), .regs_o(regs_o)
);

// File: tb/tb_ser_reg_slave.sv
`timescale 1ns/1ps
module tb_ser_reg_slave;
  localparam int NR = 6;
  localparam logic [11:0] SA = 12'h005;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1;
  logic sdin = 1'b0;
  logic [15:0] status_i = 16'hBEEF;
  wire sdout;
  logic [NR*16-1:0] regs_o;
  int checks = 0, fails = 0, edge_err = 0;

  pullup (sdout);
  always #2.5 clk = ~clk;

  ser_reg_slave #(.NUM_REGS(NR), .STATUS_ADDR(SA)) dut (
    .rst_n(rst_n), .sclk(clk), .cs_n(cs_n), .sdin(sdin),
    .sdout(sdout), .status_i(status_i), .regs_o(regs_o)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] rg(input int k);
    return regs_o[k*16 +: 16];
  endfunction

  task automatic xfer_word(input logic [15:0] tx, output logic [15:0] rx);
    for (int i = 15; i >= 0; i--) begin
      sdin = tx[i];
      #2;
      rx[i] = sdout;
      @(posedge clk);
      #1;
      if (sdout !== rx[i]) edge_err++;
      @(negedge clk);
    end
  endtask

  task automatic begin_acc();
    @(negedge clk);
    cs_n = 1'b0;
  endtask

  task automatic end_acc();
    cs_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr(input logic [15:0] cmd, input logic [15:0] data, output logic [15:0] rx);
    logic [15:0] junk;
    begin_acc();
    xfer_word(cmd, junk);
    xfer_word(data, rx);
    end_acc();
  endtask

  task automatic rd(input logic [15:0] cmd, output logic [15:0] data, output logic [15:0] cmd_rx);
    begin_acc();
    xfer_word(cmd, cmd_rx);
    xfer_word(16'h0000, data);
    end_acc();
  endtask

  task automatic t_reset();
    logic [15:0] d, c;
    for (int k = 0; k < NR; k++) chk("R1 reg clear", rg(k), 16'h0);
    chk("R1 idle sdout low", {15'h0, sdout}, 16'h0);
    rd(16'h8000, d, c);
    chk("R1 read reg0", d, 16'h0);
    chk("R8 driven low in command", c, 16'h0000);
  endtask

  task automatic t_write_read();
    logic [15:0] d, c;
    wr(16'h5002, 16'hA5C3, d);
    chk("R2 parallel reg2", rg(2), 16'hA5C3);
    chk("R2 reserved bits ignored reg0", rg(0), 16'h0);
    rd(16'h8002, d, c);
    chk("R4 read reg2", d, 16'hA5C3);
    rd(16'hF002, d, c);
    chk("R2 read with reserved bits", d, 16'hA5C3);
    chk("R4 output stable across rising edge", 16'(edge_err), 16'h0);
  endtask

  task automatic t_partial();
    logic [15:0] d;
    wr(16'h0003, 16'h1234, d);
    chk("R2 write reg3", rg(3), 16'h1234);
    begin_acc();
    xfer_word(16'h0003, d);
    for (int i = 0; i < 8; i++) begin
      sdin = 1'b1;
      @(negedge clk);
    end
    end_acc();
    chk("R3 partial word discarded", rg(3), 16'h1234);
    begin_acc();
    for (int i = 0; i < 5; i++) begin
      sdin = 1'b1;
      @(negedge clk);
    end
    end_acc();
    wr(16'h0003, 16'h4321, d);
    chk("R6 restart after aborted command", rg(3), 16'h4321);
  endtask

  task automatic t_multi();
    logic [15:0] c, d0, d1, d2;
    begin_acc();
    xfer_word(16'h8002, c);
    xfer_word(16'h0, d0);
    xfer_word(16'h0, d1);
    xfer_word(16'h0, d2);
    end_acc();
    chk("R5 first word", d0, 16'hA5C3);
    chk("R5 second word", d1, 16'hA5C3);
    chk("R5 third word", d2, 16'hA5C3);
    begin_acc();
    xfer_word(16'h0004, c);
    xfer_word(16'h1111, c);
    chk("R11 first data word committed", rg(4), 16'h1111);
    xfer_word(16'h2222, c);
    end_acc();
    chk("R11 second data word committed", rg(4), 16'h2222);
  endtask

  task automatic t_idle();
    logic [15:0] d, c;
    for (int i = 0; i < 40; i++) begin
      sdin = i[0];
      @(negedge clk);
    end
    chk("R6 idle reg2", rg(2), 16'hA5C3);
    chk("R6 idle reg3", rg(3), 16'h4321);
    chk("R6 idle reg4", rg(4), 16'h2222);
    rd(16'h8003, d, c);
    chk("R6 access after idle clocks", d, 16'h4321);
  endtask

  task automatic t_status();
    logic [15:0] d, c;
    rd(16'h8005, d, c);
    chk("R10 status read", d, 16'hBEEF);
    wr(16'h0005, 16'hFFFF, d);
    chk("R10 status write blocked", rg(5), 16'h0);
    rd(16'h8005, d, c);
    chk("R10 status unchanged", d, 16'hBEEF);
    rd(16'h8006, d, c);
    chk("R10 out of range read 6", d, 16'h0);
    rd(16'h8020, d, c);
    chk("R10 out of range read 0x020", d, 16'h0);
    wr(16'h0020, 16'h0003, d);
    chk("R10 aliased write ignored", rg(0), 16'h0);
    wr(16'h0006, 16'h7777, d);
    for (int k = 0; k < NR; k++) begin
      if (k == 2 || k == 3 || k == 4) continue;
      chk("R10 no stray write", rg(k), 16'h0);
    end
  endtask

  task automatic t_shared();
    logic [15:0] d, c;
    wr(16'h0000, 16'h0001, d);
    chk("R8 write data phase driven low", d, 16'h0000);
    chk("R7 idle released", {15'h0, sdout}, 16'h0001);
    rd(16'h8002, d, c);
    chk("R7 read data driven", d, 16'hA5C3);
    chk("R7 command released", c, 16'hFFFF);
    wr(16'h0003, 16'h0000, d);
    chk("R7 write data released", d, 16'hFFFF);
    chk("R2 write zero under shared mode", rg(3), 16'h0000);
  endtask

  task automatic t_link();
    logic [15:0] d, c;
    wr(16'h0000, 16'h0003, d);
    rd(16'h8002, d, c);
    chk("R9 read released", d, 16'hFFFF);
    chk("R9 idle released", {15'h0, sdout}, 16'h0001);
    wr(16'h0000, 16'h0000, d);
    chk("R8 idle driven again", {15'h0, sdout}, 16'h0000);
    rd(16'h8002, d, c);
    chk("R8 read after re-enable", d, 16'hA5C3);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #12 rst_n = 1'b1;
    t_reset();
    t_write_read();
    t_partial();
    t_multi();
    t_idle();
    t_status();
    t_shared();
    t_link();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule